// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating analog-to-digital converter. An external analog front end provides the switches, the buffer, the integrator and the zero-crossing comparator. The block selects the front end's operating phase through a two-bit code and times each phase with the system clock. It reads the comparator to find the input polarity and to detect when the integrator has run back to its starting level.

A conversion steps through four phases: auto-zero, then signal integration for a fixed number of clocks, then reference deintegration, then integrator zero. The deintegration time is the reading. It is measured against the fixed integration length, so the ratio of the two gives the input as a fraction of the reference.

The magnitude, a sign bit and an overrange bit are captured together and announced with a one-clock strobe. The same word is also loaded into a shift register that a host can clock out at any later time. After integrator zero, a new conversion starts only while the enable input is high.

Top module: `dslope_ctrl`

## Requirements
- R1: The phase code on {phase_a, phase_b} is 2'b01 for auto-zero, 2'b10 for integrate, 2'b11 for deintegrate and 2'b00 for integrator zero. Phases always advance in the order auto-zero, integrate, deintegrate, integrator zero, and then back to auto-zero.
- R2: Auto-zero lasts exactly AZ_LEN clocks and integrate lasts exactly INT_LEN clocks. Deintegrate is presented on the clock that follows the last integrate clock.
- R3: Integrator zero lasts at least IZ_LEN clocks. It moves to auto-zero only on a clock where that minimum has elapsed and `en` is high. While `en` is low the code stays 2'b00.
- R4: The comparator passes through a two-flop synchronizer. Deintegration ends on the first falling edge of the synchronized level. The magnitude is the number of whole deintegrate clocks that came before the clock on which that edge is seen.
- R5: The sign bit is the inverse of the synchronized comparator level on the last integrate clock (1 = negative). It is published with the magnitude.
- R6: If no falling edge is seen within FS_LEN deintegrate clocks, deintegration ends after exactly FS_LEN clocks. In that case the overrange bit is 1 and the magnitude saturates at FS_LEN. Otherwise the overrange bit is 0.
- R7: Comparator transitions outside deintegration have no effect on the phase sequence or on the published result.
- R8: `result_valid` is high for exactly one clock, on the first integrator-zero clock, together with the new magnitude, sign and overrange values. These values hold until the next capture.
- R9: On the clock after `result_valid`, the shift register holds the word {overrange, sign, magnitude} and `ser_dout` shows its most significant bit. Each later clock with `ser_shift` high moves the word one place toward `ser_dout`, with zeros filling in behind. A load takes priority over a shift.
- R10: Synchronous reset puts the block in integrator zero with its minimum already elapsed. It also clears the result, the strobe and the serial output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Allows the next conversion to start |
| comp_in | input | 1 | Asynchronous comparator output from the front end |
| ser_shift | input | 1 | Advances the serial result by one bit |
| phase_a | output | 1 | Phase code, upper bit |
| phase_b | output | 1 | Phase code, lower bit |
| result_mag | output | MAG_W | Deintegration count |
| result_neg | output | 1 | Sign of the reading, 1 = negative |
| result_ovr | output | 1 | Full-scale limit reached |
| result_valid | output | 1 | One-clock capture strobe |
| ser_dout | output | 1 | Serial result, most significant bit first |

## Verification
The properties assume that `comp_in` can change at any time. They make no claim about the value of the magnitude beyond its full-scale bound, because that value depends on when the analog crossing happens. They also assume that `en` and `ser_shift` are plain levels sampled at the clock. The stimulus changes every input only on the falling clock edge. It holds the comparator at the chosen polarity for all of auto-zero and integrate. During deintegration it lowers the comparator after a programmed delay, and some delays are chosen to land beyond the full-scale limit. In some conversions it toggles the comparator on every clock of integrator zero, so the edge filter is exercised.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

  typedef enum logic [1:0] {
    PH_IZ  = 2'b00,
    PH_AZ  = 2'b01,
    PH_INT = 2'b10,
    PH_DE  = 2'b11
  } phase_t;

  function automatic int max_of2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dslope_edge.sv
module dslope_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= din;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign fall = prev_q & ~chain[STAGES-1];

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int AZ_LEN  = 123093,
  parameter int INT_LEN = 123093,
  parameter int IZ_LEN  = 1843,
  parameter int FS_LEN  = 246185,
  parameter int MAG_W   = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cmp_lvl,
  input  logic             cmp_fall,
  output phase_t           ph,
  output logic [MAG_W-1:0] mag,
  output logic             neg,
  output logic             ovr,
  output logic             valid
);

  localparam int MAXL = max_of2(max_of2(AZ_LEN, INT_LEN), max_of2(IZ_LEN, FS_LEN));
  localparam int TW   = $clog2(MAXL + 1);
  localparam logic [TW-1:0] AZ_END  = TW'(AZ_LEN - 1);
  localparam logic [TW-1:0] INT_END = TW'(INT_LEN - 1);
  localparam logic [TW-1:0] IZ_END  = TW'(IZ_LEN - 1);
  localparam logic [TW-1:0] FS_END  = TW'(FS_LEN - 1);

  logic [TW-1:0] tmr;
  logic          sign_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IZ;
      tmr    <= IZ_END;
      sign_q <= 1'b0;
      mag    <= '0;
      neg    <= 1'b0;
      ovr    <= 1'b0;
      valid  <= 1'b0;
    end else begin
      valid <= 1'b0;
      unique case (ph)
        PH_IZ: begin
          if (tmr >= IZ_END) begin
            if (en) begin
              ph  <= PH_AZ;
              tmr <= '0;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        PH_AZ: begin
          if (tmr == AZ_END) begin
            ph  <= PH_INT;
            tmr <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        PH_INT: begin
          if (tmr == INT_END) begin
            ph     <= PH_DE;
            tmr    <= '0;
            sign_q <= ~cmp_lvl;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        PH_DE: begin
          if (cmp_fall) begin
            ph    <= PH_IZ;
            tmr   <= '0;
            mag   <= MAG_W'(tmr);
            neg   <= sign_q;
            ovr   <= 1'b0;
            valid <= 1'b1;
          end else if (tmr == FS_END) begin
            ph    <= PH_IZ;
            tmr   <= '0;
            mag   <= MAG_W'(FS_LEN);
            neg   <= sign_q;
            ovr   <= 1'b1;
            valid <= 1'b1;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: ph <= PH_IZ;
      endcase
    end
  end

  assert_az_next_R1: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_AZ) |=> (ph == PH_AZ || ph == PH_INT));
  assert_int_next_R1: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_INT) |=> (ph == PH_INT || ph == PH_DE));
  assert_de_next_R1: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_DE) |=> (ph == PH_DE || ph == PH_IZ));
  assert_iz_next_R1: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_IZ) |=> (ph == PH_IZ || ph == PH_AZ));
  assert_int_len_R2: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_DE && $past(ph) == PH_INT) |-> ($past(tmr) == INT_END));
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_IZ && !en) |=> (ph == PH_IZ));
  assert_mag_bound_R6: assert property (@(posedge clk) disable iff (rst)
    valid |-> (mag <= MAG_W'(FS_LEN)));
  assert_ovr_sat_R6: assert property (@(posedge clk) disable iff (rst)
    (valid && ovr) |-> (mag == MAG_W'(FS_LEN)));
  assert_valid_src_R7: assert property (@(posedge clk) disable iff (rst)
    valid |-> ($past(ph) == PH_DE && ph == PH_IZ));
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

endmodule

// File: rtl/dslope_shift.sv
module dslope_shift #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         shift,
  output logic         dout
);

  logic [W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst)        sreg <= '0;
    else if (load)  sreg <= word;
    else if (shift) sreg <= {sreg[W-2:0], 1'b0};
  end

  assign dout = sreg[W-1];

  assert_load_msb_R9: assert property (@(posedge clk) disable iff (rst)
    load |=> (dout == $past(word[W-1])));
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!load && !shift) |=> $stable(dout));

endmodule

// File: rtl/dslope_ctrl.sv
module dslope_ctrl
  import dslope_pkg::*;
#(
  parameter int AZ_LEN   = 123093,
  parameter int INT_LEN  = 123093,
  parameter int IZ_LEN   = 1843,
  parameter int FS_LEN   = 246185,
  parameter int SYNC_STG = 2,
  parameter int MAG_W    = $clog2(FS_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             comp_in,
  input  logic             ser_shift,
  output logic             phase_a,
  output logic             phase_b,
  output logic [MAG_W-1:0] result_mag,
  output logic             result_neg,
  output logic             result_ovr,
  output logic             result_valid,
  output logic             ser_dout
);

  localparam int WORD_W = MAG_W + 2;

  logic   cmp_lvl;
  logic   cmp_fall;
  phase_t ph;

  dslope_edge #(.STAGES(SYNC_STG)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .din  (comp_in),
    .lvl  (cmp_lvl),
    .fall (cmp_fall)
  );

  dslope_seq #(
    .AZ_LEN (AZ_LEN),
    .INT_LEN(INT_LEN),
    .IZ_LEN (IZ_LEN),
    .FS_LEN (FS_LEN),
    .MAG_W  (MAG_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .cmp_lvl (cmp_lvl),
    .cmp_fall(cmp_fall),
    .ph      (ph),
    .mag     (result_mag),
    .neg     (result_neg),
    .ovr     (result_ovr),
    .valid   (result_valid)
  );

  dslope_shift #(.W(WORD_W)) u_shift (
    .clk  (clk),
    .rst  (rst),
    .load (result_valid),
    .word ({result_ovr, result_neg, result_mag}),
    .shift(ser_shift),
    .dout (ser_dout)
  );

  assign phase_a = ph[1];
  assign phase_b = ph[0];

endmodule

// File: tb/sim_dslope_ctrl.sv
module sim_dslope_ctrl;

  localparam int AZ  = 6;
  localparam int INTL = 8;
  localparam int IZL = 4;
  localparam int FS  = 20;
  localparam int MW  = $clog2(FS + 1);
  localparam int W   = MW + 2;
  localparam int NSC = 6;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, comp = 1'b0, ser_shift = 1'b0;
  logic phase_a, phase_b, result_neg, result_ovr, result_valid, ser_dout;
  logic [MW-1:0] result_mag;

  always #2 clk = ~clk;

  dslope_ctrl #(.AZ_LEN(AZ), .INT_LEN(INTL), .IZ_LEN(IZL), .FS_LEN(FS)) u0 (
    .clk(clk), .rst(rst), .en(en), .comp_in(comp), .ser_shift(ser_shift),
    .phase_a(phase_a), .phase_b(phase_b), .result_mag(result_mag),
    .result_neg(result_neg), .result_ovr(result_ovr),
    .result_valid(result_valid), .ser_dout(ser_dout)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // phase codes: 0 izero, 1 autozero, 2 integrate, 3 deintegrate
  int m_ph = 0, m_cnt = IZL - 1, m_mag = 0;
  bit m_sign = 0, m_neg = 0, m_ovr = 0, m_valid = 0;
  logic [W-1:0] m_sreg = '0;
  bit hist[$] = '{0, 0, 0};

  always @(posedge clk) begin
    bit cs, fl;
    cs = hist[1];
    fl = hist[2] & ~cs;
    if (rst) m_sreg = '0;
    else if (m_valid) m_sreg = {m_ovr, m_neg, MW'(m_mag)};
    else if (ser_shift) m_sreg = {m_sreg[W-2:0], 1'b0};
    if (rst) begin
      m_ph = 0; m_cnt = IZL - 1; m_sign = 0;
      m_mag = 0; m_neg = 0; m_ovr = 0; m_valid = 0;
    end else begin
      m_valid = 0;
      case (m_ph)
        0: if (m_cnt >= IZL - 1) begin
             if (en) begin m_ph = 1; m_cnt = 0; end
           end else m_cnt++;
        1: if (m_cnt == AZ - 1) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
        2: if (m_cnt == INTL - 1) begin m_ph = 3; m_cnt = 0; m_sign = ~cs; end
           else m_cnt++;
        default: if (fl) begin
             m_ph = 0; m_mag = m_cnt; m_neg = m_sign; m_ovr = 0; m_valid = 1; m_cnt = 0;
           end else if (m_cnt == FS - 1) begin
             m_ph = 0; m_mag = FS; m_neg = m_sign; m_ovr = 1; m_valid = 1; m_cnt = 0;
           end else m_cnt++;
      endcase
    end
    hist.push_front(rst ? 1'b0 : comp);
    void'(hist.pop_back());
  end

  int  sc_k[NSC]     = '{5, 7, 0, 100, 16, 17};
  bit  sc_pol[NSC]   = '{1, 0, 1, 1, 0, 1};
  bit  sc_noise[NSC] = '{0, 1, 1, 0, 1, 0};
  int  idx = 0, dcnt = 0, run = 0, prev_ph = 0;
  logic [W-1:0] last_word = '0;

  function automatic int next_ph(input int p);
    case (p)
      1: return 2;
      2: return 3;
      3: return 0;
      default: return 1;
    endcase
  endfunction

  always @(negedge clk) begin
    int cur, sel;
    cur = {phase_a, phase_b};
    sel = (idx < NSC) ? idx : NSC - 1;
    if (!rst) begin
      chk(cur == m_ph, "R1 phase code", cur, m_ph);
      chk(result_valid == m_valid, "R8 strobe", result_valid, m_valid);
      chk(ser_dout == m_sreg[W-1], "R9 serial bit", ser_dout, m_sreg[W-1]);
      if (cur != prev_ph) begin
        chk(cur == next_ph(prev_ph), "R1 order", cur, next_ph(prev_ph));
        if (prev_ph == 2) chk(run == INTL, "R2 integrate length", run, INTL);
        if (prev_ph == 1) chk(run == AZ, "R2 autozero length", run, AZ);
        if (prev_ph == 0 && idx > 0) chk(run >= IZL, "R3 izero minimum", run, IZL);
        run = 1;
      end else run++;
      prev_ph = cur;
      if (m_valid) begin
        chk(result_mag == MW'(m_mag), "R4 magnitude", result_mag, m_mag);
        chk(result_neg == m_neg, "R5 sign", result_neg, m_neg);
        chk(result_ovr == m_ovr, "R6 overrange", result_ovr, m_ovr);
        if (m_ovr) chk(result_mag == MW'(FS), "R6 saturation", result_mag, FS);
        if (sc_noise[sel]) chk(result_mag == MW'(m_mag), "R7 noise ignored", result_mag, m_mag);
        last_word = {m_ovr, m_neg, MW'(m_mag)};
      end
      if (result_valid) idx++;
    end
    // stimulus
    if (cur == 3) begin
      comp = (dcnt < sc_k[sel]);
      dcnt++;
    end else begin
      dcnt = 0;
      if (cur == 0 && sc_noise[sel]) comp = ~comp;
      else if (cur == 1 || cur == 2) comp = sc_pol[sel];
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({phase_a, phase_b} == 2'b00, "R10 reset phase", {phase_a, phase_b}, 0);
    chk(result_valid == 1'b0, "R10 reset strobe", result_valid, 0);
    chk(result_mag == '0, "R10 reset magnitude", result_mag, 0);
    chk(ser_dout == 1'b0, "R10 reset serial", ser_dout, 0);
    rst = 1'b0;
    repeat (12) begin
      @(negedge clk);
      chk({phase_a, phase_b} == 2'b00, "R3 hold while disabled", {phase_a, phase_b}, 0);
    end
    en = 1'b1;
    wait (idx == NSC);
    @(negedge clk);
    en = 1'b0;
    repeat (IZL + 6) @(negedge clk);
    chk({phase_a, phase_b} == 2'b00, "R3 parked after disable", {phase_a, phase_b}, 0);
    ser_shift = 1'b1;
    for (int i = 0; i < W; i++) begin
      chk(ser_dout == last_word[W-1-i], "R9 serial word bit", ser_dout, last_word[W-1-i]);
      @(negedge clk);
    end
    chk(ser_dout == 1'b0, "R9 zero fill", ser_dout, 0);
    ser_shift = 1'b0;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", idx, NSC);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule